// File: doc/BRIEF.md
# Legacy Shadow Window Decoder

This block sits in a PC-style host bridge. It decides where each memory access to the legacy area between 0xC0000 and 0xFFFFF goes. A read or a write is sent either to system DRAM or to the firmware/ROM path. Seven byte-wide attribute registers, reached through a small configuration port, hold a pair of 4-bit attribute fields each. Every field governs one region, and a region's reads and writes are steered independently.

The block also makes the 64 KiB window just below 4 GiB present the firmware image. That window always goes to the ROM path. It yields the same image offset as the 64 KiB ISA firmware region just below 1 MiB. Any other address goes to DRAM. Each request presented with `mem_valid` produces a one-cycle route strobe one clock later. The strobe carries the target and, for ROM-bound traffic, the offset into the image.

Top module: `shadow_decode`

## Requirements
- R1: After reset all seven attribute registers (configuration offsets 0x59 to 0x5F) read 0x00, so every access to a legacy region goes to the ROM path.
- R2: A configuration read of offset 0x59 to 0x5F returns the stored byte unchanged, both nibbles included. A configuration write to any other offset is ignored, and reads of such offsets return 0x00.
- R3: Region i is governed by register 0x59 + i/2. Even regions use bits [3:0] and odd regions use bits [7:4]. Within a field, bit 0 enables reads and bit 1 enables writes.
- R4: Region 1 spans 0xF0000 to 0xFFFFF. Regions 2 to 13 are consecutive 16 KiB blocks rising from 0xC0000 to 0xEFFFF. Region 0 maps no address.
- R5: A read of a region with its read-enable set goes to DRAM (`rd_to_rom` = 0). With read-enable clear it goes to ROM (`rd_to_rom` = 1).
- R6: A write to a region with its write-enable set goes to DRAM (`wr_to_rom` = 0). With write-enable clear it goes to ROM, where it is dropped (`wr_to_rom` = 1).
- R7: Read and write steering of one region are independent: with only write-enable set, writes go to DRAM while reads go to ROM.
- R8: Any access with address bits [31:16] all ones goes to ROM regardless of the attributes. For every ROM-bound access `rom_off` equals the low 16 address bits, so 0xFFFFxxxx and 0xFxxxx give the same image offset.
- R9: Accesses outside all regions and outside the top window go to DRAM, with `rom_off` = 0.
- R10: Each request accepted with `mem_valid` yields exactly one strobe, `rd_strobe` for a read or `wr_strobe` for a write, in the next cycle. A request presented in the cycle after a configuration write is steered by the new attributes.
- R11: Clearing a field back to 0 after it enabled reads makes reads of that region go to ROM again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for `cfg_addr` (combinational) |
| mem_valid | input | 1 | Memory request present |
| mem_write | input | 1 | 1 = write request, 0 = read request |
| mem_addr | input | 32 | Request byte address |
| rd_strobe | output | 1 | A read was steered (one cycle after the request) |
| rd_to_rom | output | 1 | Steered read goes to ROM (1) or DRAM (0) |
| wr_strobe | output | 1 | A write was steered (one cycle after the request) |
| wr_to_rom | output | 1 | Steered write goes to ROM (1) or DRAM (0) |
| rom_off | output | 16 | Offset into the firmware image for ROM-bound accesses, else 0 |

## Verification
The properties assume that `mem_write` and `mem_addr` are meaningful only while `mem_valid` is high. They also assume that the configuration port changes only away from the clock edge and holds its values for the whole cycle. The stimulus drives every request and every configuration access one time unit after a rising edge and lowers `mem_valid` between requests. The steering checks therefore always see a settled attribute set. Each region is probed by itself with each attribute combination, and its neighbours are probed too, so a wrong nibble or block index shows up as a wrong target.

// File: rtl/shd_pkg.sv
package shd_pkg;

    localparam int            NUM_ATTR_REGS = 7;
    localparam logic [7:0]    ATTR_BASE     = 8'h59;
    localparam logic [19:0]   LEGACY_LO     = 20'hC0000;
    localparam logic [19:0]   LEGACY_HI     = 20'hEFFFF;
    localparam logic [19:0]   ISA_FW_LO     = 20'hF0000;
    localparam logic [5:0]    BLK_BIAS      = 6'd46;   // block 0x30 maps to region 2
    localparam int            IDX_W         = 4;

    typedef enum logic {
        TGT_DRAM = 1'b0,
        TGT_ROM  = 1'b1
    } target_e;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } attr_t;

    typedef struct packed {
        logic             legacy;   // address falls in one of regions 1..13
        logic [IDX_W-1:0] idx;      // region number when legacy is set
        logic             top;      // firmware window under the address-space top
    } region_t;

    function automatic attr_t pick_field(logic [7:0] byte_in, logic odd);
        logic [3:0] nib;
        attr_t      a;
        nib     = odd ? byte_in[7:4] : byte_in[3:0];
        a.rd_en = nib[0];
        a.wr_en = nib[1];
        return a;
    endfunction

endpackage

// File: rtl/shd_attr_regs.sv
module shd_attr_regs
    import shd_pkg::*;
#(
    parameter int         NREG = NUM_ATTR_REGS,
    parameter logic [7:0] BASE = ATTR_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    output logic [NREG-1:0][7:0] attrs
);

    logic [NREG-1:0] hit;

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        assign hit[k] = (cfg_addr == BASE + 8'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                attrs[k] <= 8'h00;
            end else if (cfg_wr && hit[k]) begin
                attrs[k] <= cfg_wdata;
            end
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (hit[k]) begin
                cfg_rdata = attrs[k];
            end
        end
    end

endmodule

// File: rtl/shd_region_map.sv
module shd_region_map
    import shd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           reg_o
);

    logic [19:0] lo;
    logic        below_1m;
    logic [5:0]  blk_rel;
    logic        unused_bits;

    assign lo       = addr[19:0];
    assign below_1m = (addr[ADDR_W-1:20] == '0);
    assign blk_rel  = lo[19:14] - BLK_BIAS;
    assign unused_bits = ^{lo[13:0], blk_rel[5:4]};

    always_comb begin
        reg_o.legacy = 1'b0;
        reg_o.idx    = '0;
        reg_o.top    = &addr[ADDR_W-1:OFF_W];
        if (below_1m && lo >= ISA_FW_LO) begin
            reg_o.legacy = 1'b1;
            reg_o.idx    = IDX_W'(1);
        end else if (below_1m && lo >= LEGACY_LO && lo <= LEGACY_HI) begin
            reg_o.legacy = 1'b1;
            reg_o.idx    = blk_rel[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/shd_route_stage.sv
module shd_route_stage
    import shd_pkg::*;
#(
    parameter int NREG  = NUM_ATTR_REGS,
    parameter int OFF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mem_valid,
    input  logic                 mem_write,
    input  logic [OFF_W-1:0]     low_addr,
    input  region_t              reg_i,
    input  logic [NREG-1:0][7:0] attrs,
    output logic                 rd_strobe,
    output logic                 rd_to_rom,
    output logic                 wr_strobe,
    output logic                 wr_to_rom,
    output logic [OFF_W-1:0]     rom_off
);

    logic [7:0] sel_byte;
    attr_t      attr;
    target_e    tgt_rd, tgt_wr, tgt;

    always_comb begin
        sel_byte = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (reg_i.idx[IDX_W-1:1] == (IDX_W-1)'(k)) begin
                sel_byte = attrs[k];
            end
        end
        attr = pick_field(sel_byte, reg_i.idx[0]);
    end

    always_comb begin
        tgt_rd = TGT_DRAM;
        tgt_wr = TGT_DRAM;
        if (reg_i.top) begin
            tgt_rd = TGT_ROM;
            tgt_wr = TGT_ROM;
        end else if (reg_i.legacy) begin
            tgt_rd = attr.rd_en ? TGT_DRAM : TGT_ROM;
            tgt_wr = attr.wr_en ? TGT_DRAM : TGT_ROM;
        end
        tgt = mem_write ? tgt_wr : tgt_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_strobe <= 1'b0;
            rd_to_rom <= 1'b0;
            wr_strobe <= 1'b0;
            wr_to_rom <= 1'b0;
            rom_off   <= '0;
        end else begin
            rd_strobe <= mem_valid && !mem_write;
            wr_strobe <= mem_valid && mem_write;
            rd_to_rom <= mem_valid && !mem_write && (tgt == TGT_ROM);
            wr_to_rom <= mem_valid && mem_write && (tgt == TGT_ROM);
            rom_off   <= (mem_valid && tgt == TGT_ROM) ? low_addr : '0;
        end
    end

endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
    import shd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rd_strobe,
    output logic              rd_to_rom,
    output logic              wr_strobe,
    output logic              wr_to_rom,
    output logic [OFF_W-1:0]  rom_off
);

    logic [NUM_ATTR_REGS-1:0][7:0] attrs;
    region_t                       region;

    shd_attr_regs #(
        .NREG (NUM_ATTR_REGS),
        .BASE (ATTR_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .attrs     (attrs)
    );

    shd_region_map #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_map (
        .addr  (mem_addr),
        .reg_o (region)
    );

    shd_route_stage #(
        .NREG  (NUM_ATTR_REGS),
        .OFF_W (OFF_W)
    ) u_route (
        .clk       (clk),
        .rst       (rst),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .low_addr  (mem_addr[OFF_W-1:0]),
        .reg_i     (region),
        .attrs     (attrs),
        .rd_strobe (rd_strobe),
        .rd_to_rom (rd_to_rom),
        .wr_strobe (wr_strobe),
        .wr_to_rom (wr_to_rom),
        .rom_off   (rom_off)
    );

endmodule

// File: rtl/shd_checker.sv
module shd_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_strobe,
    input logic              rd_to_rom,
    input logic              wr_strobe,
    input logic              wr_to_rom,
    input logic [OFF_W-1:0]  rom_off
);

    // R10: a read request yields a read strobe only
    a_r10_read_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write) |=> (rd_strobe && !wr_strobe));

    // R10: a write request yields a write strobe only
    a_r10_write_strobe: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |=> (wr_strobe && !rd_strobe));

    // R10: no request, no strobe
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !mem_valid |=> (!rd_strobe && !wr_strobe));

    // R8: top window always reaches ROM with the low address bits as offset
    a_r8_top_window: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && (&mem_addr[ADDR_W-1:OFF_W]))
        |=> ((rd_to_rom || wr_to_rom) && rom_off == $past(mem_addr[OFF_W-1:0])));

    // R9: low memory below the legacy area goes to DRAM
    a_r9_low_dram: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_addr < ADDR_W'(32'h000C0000))
        |=> (!rd_to_rom && !wr_to_rom && rom_off == '0));

    // R9: DRAM-bound strobes carry no image offset
    a_r9_dram_no_offset: assert property (@(posedge clk) disable iff (rst)
        ((rd_strobe && !rd_to_rom) || (wr_strobe && !wr_to_rom)) |-> (rom_off == '0));

    // R10: strobes never overlap, targets never raised without a strobe
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_strobe, wr_strobe}) && !(rd_to_rom && !rd_strobe)
        && !(wr_to_rom && !wr_strobe));

    // R2: an out-of-range configuration write leaves the readback of that offset at zero
    a_r2_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && (cfg_addr < 8'h59 || cfg_addr > 8'h5F)) |-> (cfg_rdata == 8'h00));

endmodule

bind shadow_decode shd_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/shadow_decode_tb.sv
module shadow_decode_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        mem_valid = 1'b0;
    logic        mem_write = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        rd_strobe, rd_to_rom, wr_strobe, wr_to_rom;
    logic [15:0] rom_off;

    always #10 clk = ~clk;   // 50 MHz

    shadow_decode u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .rd_strobe (rd_strobe),
        .rd_to_rom (rd_to_rom),
        .wr_strobe (wr_strobe),
        .wr_to_rom (wr_to_rom),
        .rom_off   (rom_off)
    );

    typedef struct {
        bit        wr;
        bit        rom;
        bit [15:0] off;
        string     req;
        bit [31:0] addr;
    } exp_t;

    exp_t     sb[$];
    int       checks = 0;
    int       failures = 0;
    bit       finished = 0;
    bit [7:0] model [7];

    // Bench-side region lookup: -1 when the address is in no region
    function automatic int region_of(bit [31:0] a);
        if (a >= 32'hF0000 && a <= 32'hFFFFF) return 1;
        for (int i = 2; i <= 13; i++) begin
            if (a >= 32'hC0000 + (i - 2) * 32'h4000 && a < 32'hC0000 + (i - 1) * 32'h4000)
                return i;
        end
        return -1;
    endfunction

    function automatic bit [3:0] field_of(int i);
        return (i % 2 == 1) ? model[i / 2][7:4] : model[i / 2][3:0];
    endfunction

    task automatic cfg_write(input bit [7:0] a, input bit [7:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 8'h59 && a <= 8'h5F) model[a - 8'h59] = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input bit [7:0] a, input string req);
        bit [7:0] e;
        e = (a >= 8'h59 && a <= 8'h5F) ? model[a - 8'h59] : 8'h00;
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        checks++;
        if (cfg_rdata !== e) begin
            failures++;
            $display("FAIL %s cfg offset 0x%02h actual=0x%02h expected=0x%02h", req, a, cfg_rdata, e);
        end
    endtask

    // Driver: computes the expected steering and pushes it to the scoreboard
    task automatic access(input bit [31:0] a, input bit wr, input string req);
        exp_t e;
        int   r;
        bit   rom;
        r = region_of(a);
        if (a[31:16] == 16'hFFFF) rom = 1'b1;
        else if (r > 0) rom = wr ? !field_of(r)[1] : !field_of(r)[0];
        else rom = 1'b0;
        e.wr = wr; e.rom = rom; e.off = rom ? a[15:0] : 16'h0; e.req = req; e.addr = a;
        @(posedge clk); #1;
        mem_valid = 1'b1; mem_write = wr; mem_addr = a;
        sb.push_back(e);
        @(posedge clk); #1;
        mem_valid = 1'b0;
    endtask

    // Monitor: pops and compares each strobe away from the clock edge
    always @(negedge clk) begin
        if (!rst && (rd_strobe || wr_strobe)) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected strobe actual=rd%0b/wr%0b expected=none", rd_strobe, wr_strobe);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (wr_strobe !== e.wr || rd_strobe !== !e.wr
                    || (e.wr ? wr_to_rom : rd_to_rom) !== e.rom || rom_off !== e.off) begin
                    failures++;
                    $display("FAIL %s addr=0x%08h actual=wr%0b rom%0b off=0x%04h expected=wr%0b rom%0b off=0x%04h",
                             e.req, e.addr, wr_strobe, e.wr ? wr_to_rom : rd_to_rom, rom_off,
                             e.wr, e.rom, e.off);
                end
            end
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            report();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 7; k++) model[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values and default steering
        for (int k = 0; k < 7; k++) cfg_check(8'h59 + 8'(k), "R1");
        access(32'h000C0000, 1'b0, "R1");
        access(32'h000F1234, 1'b1, "R1");

        // R2: readback of both nibbles, out-of-range offsets ignored
        cfg_write(8'h5A, 8'hA5);
        cfg_check(8'h5A, "R2");
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_check(8'h58, "R2");
        cfg_check(8'h60, "R2");
        for (int k = 0; k < 7; k++) cfg_check(8'h59 + 8'(k), "R2");
        cfg_write(8'h5A, 8'h00);

        // R3 R4 R5 R6: each region alone with read-enable, then write-enable
        for (int i = 1; i <= 13; i++) begin
            bit [31:0] base;
            bit [7:0]  off_reg;
            base    = (i == 1) ? 32'hF0000 : 32'hC0000 + (i - 2) * 32'h4000;
            off_reg = 8'h59 + 8'(i / 2);
            cfg_write(off_reg, (i % 2 == 1) ? 8'h10 : 8'h01);
            access(base, 1'b0, "R5");
            access(base + 32'h3FFF, 1'b0, "R4");
            access(base + 32'h100, 1'b1, "R6");
            if (i >= 2 && i <= 12) access(base + 32'h4000, 1'b0, "R3");
            if (i > 2) access(base - 32'h1, 1'b0, "R4");
            cfg_write(off_reg, (i % 2 == 1) ? 8'h20 : 8'h02);
            access(base + 32'h200, 1'b1, "R6");
            access(base + 32'h200, 1'b0, "R7");
            cfg_write(off_reg, 8'h00);
        end

        // R11: enable then clear a field
        cfg_write(8'h5F, 8'h30);
        access(32'h000EC010, 1'b0, "R11");
        cfg_write(8'h5F, 8'h00);
        access(32'h000EC010, 1'b0, "R11");

        // R8: top window ignores attributes and matches the ISA offset
        cfg_write(8'h59, 8'h33);
        access(32'hFFFF1234, 1'b0, "R8");
        access(32'hFFFF1234, 1'b1, "R8");
        cfg_write(8'h59, 8'h00);
        access(32'h000F1234, 1'b0, "R8");

        // R9: addresses outside every region
        access(32'h000A0000, 1'b0, "R9");
        access(32'h000BFFFF, 1'b1, "R9");
        access(32'h00100000, 1'b0, "R9");
        access(32'hFFFE0000, 1'b1, "R9");

        // R10: request right after a configuration write uses the new value
        cfg_write(8'h5B, 8'h03);
        access(32'h000C8000, 1'b0, "R10");
        access(32'h000C8000, 1'b1, "R10");

        repeat (4) @(posedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R10 missing strobes actual=%0d expected=0", sb.size());
        end
        finished = 1;
        report();
        $finish;
    end

endmodule